// File: doc/BRIEF.md
# NCO Phase and Frequency Control

This block is the phase-generation core of a quadrature numerically controlled oscillator. A host writes 16-bit halves of the frequency words and a phase word into staging registers through a small synchronous write port with a 3-bit address. Separate active-low transfer enables then copy the staged words into working registers: a center frequency, an offset frequency and a phase offset. Each enable is captured on one clock edge and acts on the next.

The working frequency registers are summed into a 32-bit increment. An inhibit input can force the offset term to zero. A wrapping 32-bit accumulator integrates the increment, and an initialise input can zero its feedback so that it restarts from the bare increment. The phase offset comes either from the programmed phase word or from a 3-bit PSK code that selects one of eight octants. It is added to the upper half of the accumulator. The upper 28 bits of that sum are registered and presented as the instantaneous phase for a downstream sine/cosine stage.

Top module: `nco_phase_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all staging, working, accumulator and output registers to zero and returns every captured enable to its inactive level, so phase_out reads 0.
- R2: A write occurs on a clock edge only when cs_n and wr_n are both low. Address 000 writes bits 15:0 of the center staging word, 001 writes bits 31:16, 010 writes bits 15:0 of the offset staging word, 011 writes bits 31:16, and 110 writes the phase staging word. With either strobe high, nothing is stored.
- R3: The enables cf_ld_n, of_ld_n and po_ld_n are registered on one edge, and the working register loads on the following edge. phase_out shows the result one edge later, that is three edges after the enable is driven. Without its enable, a working register keeps its value even when its staging word changes.
- R4: The increment equals center plus offset, modulo 2^32.
- R5: While the registered ofs_inh_n is low, the offset term of the increment is zero. The offset register still loads and keeps its contents, so releasing the inhibit restores the sum.
- R6: The accumulator adds the increment on each edge where the registered acc_en_n is low, wraps modulo 2^32, and holds otherwise.
- R7: On an edge where the registered acc_init_n and acc_en_n are both low, the accumulator loads the bare increment. acc_init_n alone, with acc_en_n high, leaves the accumulator unchanged.
- R8: phase_out is bits 31:4 of (accumulator + phase offset × 2^16) modulo 2^32, registered one edge after its operands.
- R9: With the registered psk_sel high, a phase offset load takes the phase staging word. With it low, the load takes the octant value in bits 15:13 and zeros in bits 12:0.
- R10: psk_code values 0 through 7 select the octants 0, 1, 2, 3, 6, 7, 4, 5 (0, 45, 90, 135, 270, 315, 180 and 225 degrees).
- R11: The phase offset register changes only on edges where the registered po_ld_n is low. A change of psk_code or psk_sel alone has no effect.
- R12: Writes to addresses 100, 101 and 111 change none of the frequency or phase staging words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Write select, active low |
| wr_n | input | 1 | Write strobe, active low, sampled on clk |
| addr | input | 3 | Staging register address |
| wdata | input | 16 | Write data half-word |
| cf_ld_n | input | 1 | Center frequency transfer enable, active low |
| of_ld_n | input | 1 | Offset frequency transfer enable, active low |
| po_ld_n | input | 1 | Phase offset transfer enable, active low |
| ofs_inh_n | input | 1 | Offset term inhibit, active low |
| acc_init_n | input | 1 | Accumulator feedback zeroing, active low |
| acc_en_n | input | 1 | Accumulator step enable, active low |
| psk_sel | input | 1 | Phase offset source: 1 programmed word, 0 PSK code |
| psk_code | input | 3 | 8-level PSK octant code |
| phase_out | output | 28 | Instantaneous phase |

## Verification
The bench builds the block with its default widths: 16-bit halves, a 32-bit accumulator and a 28-bit phase output. These widths make the modulo-2^32 wrap of both the accumulator and the phase-offset sum reachable in a few clocks when increments such as 0x40000000 are used. Because the accumulator can be restarted from the bare increment, each working frequency can be read back as one exact phase value. The three-edge enable pipeline is probed edge by edge through the phase offset path.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Number of PSK code bits (eight phase levels).
    localparam int PSK_W = 3;

    // Write address map. Timer halves (100, 101) and 111 are accepted but not stored here.
    localparam logic [2:0] ADR_CF_LO = 3'd0;
    localparam logic [2:0] ADR_CF_HI = 3'd1;
    localparam logic [2:0] ADR_OF_LO = 3'd2;
    localparam logic [2:0] ADR_OF_HI = 3'd3;
    localparam logic [2:0] ADR_PHASE = 3'd6;

    // Control inputs after their one-clock capture stage.
    typedef struct packed {
        logic             cf_ld_n;
        logic             of_ld_n;
        logic             po_ld_n;
        logic             inh_n;
        logic             init_n;
        logic             acc_en_n;
        logic             psk_sel;
        logic [PSK_W-1:0] psk_code;
    } nco_ctl_t;

    localparam nco_ctl_t CTL_IDLE = '{
        cf_ld_n:  1'b1,
        of_ld_n:  1'b1,
        po_ld_n:  1'b1,
        inh_n:    1'b1,
        init_n:   1'b1,
        acc_en_n: 1'b1,
        psk_sel:  1'b0,
        psk_code: '0
    };

    // PSK code to octant: the upper two code values swap with the pair below them.
    function automatic logic [PSK_W-1:0] psk_octant(input logic [PSK_W-1:0] code);
        return {code[2], code[2] ^ code[1], code[0]};
    endfunction

endpackage

// File: rtl/nco_stage_regs.sv
module nco_stage_regs
    import nco_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic [2:0]            addr,
    input  logic [CTRL_W-1:0]     wdata,
    output logic [2*CTRL_W-1:0]   cf_stage,
    output logic [2*CTRL_W-1:0]   of_stage,
    output logic [CTRL_W-1:0]     ph_stage
);

    localparam int WORD_W = 2 * CTRL_W;
    localparam int NHALF  = 2;

    typedef struct packed {
        logic [WORD_W-1:0] cf;
        logic [WORD_W-1:0] of;
        logic [CTRL_W-1:0] ph;
    } stage_t;

    stage_t s_q, s_d;

    logic             wr_hit;
    logic [NHALF-1:0] cf_wr;
    logic [NHALF-1:0] of_wr;
    logic             ph_wr;

    assign wr_hit = !cs_n && !wr_n;
    assign ph_wr  = wr_hit && (addr == ADR_PHASE);

    // One write strobe per half-word of each frequency staging word.
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign cf_wr[h] = wr_hit && (addr == ((h == 0) ? ADR_CF_LO : ADR_CF_HI));
        assign of_wr[h] = wr_hit && (addr == ((h == 0) ? ADR_OF_LO : ADR_OF_HI));
    end

    always_comb begin
        s_d = s_q;
        for (int h = 0; h < NHALF; h++) begin
            if (cf_wr[h]) s_d.cf[h*CTRL_W +: CTRL_W] = wdata;
            if (of_wr[h]) s_d.of[h*CTRL_W +: CTRL_W] = wdata;
        end
        if (ph_wr) s_d.ph = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cf_stage = s_q.cf;
    assign of_stage = s_q.of;
    assign ph_stage = s_q.ph;

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cs_n || wr_n) |=> $stable(s_q)); // R2

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (addr[2] && (addr != ADR_PHASE)) |=> $stable(s_q)); // R12

endmodule

// File: rtl/nco_ctrl_sync.sv
module nco_ctrl_sync
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cf_ld_n,
    input  logic             of_ld_n,
    input  logic             po_ld_n,
    input  logic             ofs_inh_n,
    input  logic             acc_init_n,
    input  logic             acc_en_n,
    input  logic             psk_sel,
    input  logic [PSK_W-1:0] psk_code,
    output nco_ctl_t         ctl
);

    nco_ctl_t c_q, c_d;

    // Every control input passes through one capture stage before it acts.
    always_comb begin
        c_d.cf_ld_n  = cf_ld_n;
        c_d.of_ld_n  = of_ld_n;
        c_d.po_ld_n  = po_ld_n;
        c_d.inh_n    = ofs_inh_n;
        c_d.init_n   = acc_init_n;
        c_d.acc_en_n = acc_en_n;
        c_d.psk_sel  = psk_sel;
        c_d.psk_code = psk_code;
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= CTL_IDLE;
        else     c_q <= c_d;
    end

    assign ctl = c_q;

endmodule

// File: rtl/nco_freq_acc.sv
module nco_freq_acc
    import nco_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  nco_ctl_t         ctl,
    input  logic [ACC_W-1:0] cf_stage,
    input  logic [ACC_W-1:0] of_stage,
    output logic [ACC_W-1:0] acc
);

    typedef struct packed {
        logic [ACC_W-1:0] cf;
        logic [ACC_W-1:0] of;
        logic [ACC_W-1:0] acc;
    } fa_t;

    fa_t s_q, s_d;

    logic [ACC_W-1:0] of_term;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] feedback;

    always_comb begin
        s_d = s_q;

        // Working frequency registers follow their staged words while enabled.
        if (!ctl.cf_ld_n) s_d.cf = cf_stage;
        if (!ctl.of_ld_n) s_d.of = of_stage;

        // Frequency adder; the inhibit gates only the path, not the register.
        of_term = ctl.inh_n ? s_q.of : '0;
        inc     = s_q.cf + of_term;

        // Accumulator with zeroable feedback; the sum wraps at ACC_W bits.
        feedback = (!ctl.init_n) ? '0 : s_q.acc;
        if (!ctl.acc_en_n) s_d.acc = feedback + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign acc = s_q.acc;

    AST_CF_HELD: assert property (@(posedge clk) disable iff (rst)
        ctl.cf_ld_n |=> $stable(s_q.cf)); // R3

    AST_OF_KEPT_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        (!ctl.inh_n && ctl.of_ld_n) |=> $stable(s_q.of)); // R5

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_en_n |=> $stable(s_q.acc)); // R6

    AST_INIT_BARE_INC: assert property (@(posedge clk) disable iff (rst)
        (!ctl.acc_en_n && !ctl.init_n) |=> (s_q.acc == $past(inc))); // R7

endmodule

// File: rtl/nco_phase_offset.sv
module nco_phase_offset
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 16,
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  nco_ctl_t         ctl,
    input  logic [PH_W-1:0]  ph_stage,
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] phase
);

    localparam int LOW_W  = ACC_W - PH_W;   // accumulator bits below the offset
    localparam int PAD_W  = PH_W - PSK_W;   // offset bits cleared in PSK mode
    localparam int DROP_W = ACC_W - OUT_W;  // sum bits dropped at the output

    typedef struct packed {
        logic [PH_W-1:0]  po;
        logic [OUT_W-1:0] phase;
    } po_t;

    po_t s_q, s_d;

    logic [ACC_W-1:0] offset_aligned;

    always_comb begin
        s_d = s_q;

        if (!ctl.po_ld_n) begin
            if (ctl.psk_sel) s_d.po = ph_stage;
            else             s_d.po = {psk_octant(ctl.psk_code), {PAD_W{1'b0}}};
        end

        offset_aligned = {s_q.po, {LOW_W{1'b0}}};
        s_d.phase      = OUT_W'((acc + offset_aligned) >> DROP_W);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign phase = s_q.phase;

    AST_PO_HELD: assert property (@(posedge clk) disable iff (rst)
        ctl.po_ld_n |=> $stable(s_q.po)); // R11

    AST_PSK_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!ctl.po_ld_n && !ctl.psk_sel) |=> (s_q.po[PAD_W-1:0] == '0)); // R9

    AST_PSK_WORD_PATH: assert property (@(posedge clk) disable iff (rst)
        (!ctl.po_ld_n && ctl.psk_sel) |=> (s_q.po == $past(ph_stage))); // R9

endmodule

// File: rtl/nco_phase_ctrl.sv
module nco_phase_ctrl
    import nco_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int OUT_W  = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [2:0]        addr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              cf_ld_n,
    input  logic              of_ld_n,
    input  logic              po_ld_n,
    input  logic              ofs_inh_n,
    input  logic              acc_init_n,
    input  logic              acc_en_n,
    input  logic              psk_sel,
    input  logic [2:0]        psk_code,
    output logic [OUT_W-1:0]  phase_out
);

    localparam int ACC_W = 2 * CTRL_W;

    logic [ACC_W-1:0]  cf_stage;
    logic [ACC_W-1:0]  of_stage;
    logic [CTRL_W-1:0] ph_stage;
    logic [ACC_W-1:0]  acc;
    nco_ctl_t          ctl;

    nco_stage_regs #(.CTRL_W(CTRL_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .wdata    (wdata),
        .cf_stage (cf_stage),
        .of_stage (of_stage),
        .ph_stage (ph_stage)
    );

    nco_ctrl_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .cf_ld_n    (cf_ld_n),
        .of_ld_n    (of_ld_n),
        .po_ld_n    (po_ld_n),
        .ofs_inh_n  (ofs_inh_n),
        .acc_init_n (acc_init_n),
        .acc_en_n   (acc_en_n),
        .psk_sel    (psk_sel),
        .psk_code   (psk_code),
        .ctl        (ctl)
    );

    nco_freq_acc #(.ACC_W(ACC_W)) u_freq (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cf_stage (cf_stage),
        .of_stage (of_stage),
        .acc      (acc)
    );

    nco_phase_offset #(
        .ACC_W (ACC_W),
        .PH_W  (CTRL_W),
        .OUT_W (OUT_W)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .ph_stage (ph_stage),
        .acc      (acc),
        .phase    (phase)
    );

    logic [OUT_W-1:0] phase;
    assign phase_out = phase;

    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst) |-> (phase_out == '0)); // R1

endmodule

// File: tb/tb_nco_phase_ctrl.sv
`timescale 1ns/1ps
module tb_nco_phase_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic        cf_ld_n = 1'b1;
    logic        of_ld_n = 1'b1;
    logic        po_ld_n = 1'b1;
    logic        ofs_inh_n = 1'b1;
    logic        acc_init_n = 1'b1;
    logic        acc_en_n = 1'b1;
    logic        psk_sel = 1'b1;
    logic [2:0]  psk_code = 3'd0;
    logic [27:0] phase_out;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    nco_phase_ctrl dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .cf_ld_n(cf_ld_n), .of_ld_n(of_ld_n), .po_ld_n(po_ld_n), .ofs_inh_n(ofs_inh_n),
        .acc_init_n(acc_init_n), .acc_en_n(acc_en_n), .psk_sel(psk_sel),
        .psk_code(psk_code), .phase_out(phase_out)
    );

    // Expected phase from accumulator and offset: upper 28 bits of the wrapped sum.
    function automatic logic [27:0] exp_phase(input logic [31:0] acc, input logic [15:0] po);
        logic [31:0] s;
        s = acc + {po, 16'h0000};
        return s[31:4];
    endfunction

    // Octant offset from the degree table of the PSK requirement.
    function automatic logic [15:0] exp_psk(input int code);
        int deg;
        case (code)
            0: deg = 0;   1: deg = 45;  2: deg = 90;  3: deg = 135;
            4: deg = 270; 5: deg = 315; 6: deg = 180; default: deg = 225;
        endcase
        return 16'((deg / 45) * 16'h2000);
    endfunction

    task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_raw(input logic cs, input logic wr, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_n = cs; wr_n = wr; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_raw(1'b0, 1'b0, a, d);
    endtask

    task automatic load(input bit cf, input bit of, input bit po);
        @(negedge clk);
        cf_ld_n = !cf; of_ld_n = !of; po_ld_n = !po;
        @(negedge clk);
        cf_ld_n = 1'b1; of_ld_n = 1'b1; po_ld_n = 1'b1;
        tick(3);
    endtask

    // Restart the accumulator from the bare increment, then let the output settle.
    task automatic measure();
        @(negedge clk);
        acc_init_n = 1'b0; acc_en_n = 1'b0;
        @(negedge clk);
        acc_init_n = 1'b1; acc_en_n = 1'b1;
        tick(3);
    endtask

    task automatic step(input int n);
        @(negedge clk);
        acc_en_n = 1'b0;
        tick(n);
        acc_en_n = 1'b1;
        tick(3);
    endtask

    task automatic t_reset();
        chk("R1 phase after reset", phase_out, 28'h0);
        load(1, 1, 1);
        measure();
        chk("R1 cleared staging gives zero", phase_out, 28'h0);
    endtask

    task automatic t_decode();
        wr(3'd0, 16'h1234);
        wr(3'd1, 16'h0008);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0002);
        load(1, 1, 0);
        measure();
        chk("R4 center plus offset", phase_out, exp_phase(32'h000A1234, 16'h0));
        wr_raw(1'b1, 1'b0, 3'd1, 16'hFFFF);
        wr_raw(1'b0, 1'b1, 3'd0, 16'hFFFF);
        load(1, 1, 0);
        measure();
        chk("R2 strobe not both low ignored", phase_out, exp_phase(32'h000A1234, 16'h0));
    endtask

    task automatic t_unmapped();
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        load(1, 1, 1);
        measure();
        chk("R12 unmapped addresses no effect", phase_out, exp_phase(32'h000A1234, 16'h0));
    endtask

    task automatic t_inhibit();
        @(negedge clk); ofs_inh_n = 1'b0;
        tick(2);
        measure();
        chk("R5 offset term zeroed", phase_out, exp_phase(32'h00081234, 16'h0));
        wr(3'd3, 16'h0003);
        load(0, 1, 0);
        measure();
        chk("R5 offset loads while inhibited", phase_out, exp_phase(32'h00081234, 16'h0));
        @(negedge clk); ofs_inh_n = 1'b1;
        tick(2);
        measure();
        chk("R5 sum restored with new offset", phase_out, exp_phase(32'h000B1234, 16'h0));
    endtask

    task automatic t_wrap();
        wr(3'd0, 16'h0000); wr(3'd1, 16'h4000);
        wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
        load(1, 1, 0);
        measure();
        chk("R4 quarter-turn increment", phase_out, exp_phase(32'h40000000, 16'h0));
        step(3);
        chk("R6 wraps after four steps", phase_out, 28'h0);
        step(1);
        chk("R6 one step past wrap", phase_out, exp_phase(32'h40000000, 16'h0));
        tick(5);
        chk("R6 holds while disabled", phase_out, exp_phase(32'h40000000, 16'h0));
    endtask

    task automatic t_init();
        @(negedge clk); acc_init_n = 1'b0;
        @(negedge clk); acc_init_n = 1'b1;
        tick(3);
        chk("R7 init alone no effect", phase_out, exp_phase(32'h40000000, 16'h0));
        step(1);
        chk("R6 step to half turn", phase_out, exp_phase(32'h80000000, 16'h0));
        measure();
        chk("R7 reload bare increment", phase_out, exp_phase(32'h40000000, 16'h0));
    endtask

    task automatic t_hold_cf();
        wr(3'd1, 16'h1000);
        measure();
        chk("R3 staged word not loaded", phase_out, exp_phase(32'h40000000, 16'h0));
        wr(3'd1, 16'h0000);
        load(1, 0, 0);
        measure();
        chk("R4 zero increment", phase_out, 28'h0);
    endtask

    task automatic t_phase_word();
        wr(3'd6, 16'h2ABC);
        @(negedge clk); psk_sel = 1'b1; po_ld_n = 1'b0;
        @(negedge clk); po_ld_n = 1'b1;
        chk("R3 no change after capture edge", phase_out, 28'h0);
        @(negedge clk);
        chk("R3 no change after load edge", phase_out, 28'h0);
        @(negedge clk);
        chk("R3 R9 word visible third edge", phase_out, exp_phase(32'h0, 16'h2ABC));
        wr(3'd1, 16'hF000);
        load(1, 0, 0);
        measure();
        chk("R8 offset sum wraps", phase_out, exp_phase(32'hF0000000, 16'h2ABC));
        wr(3'd1, 16'h0000);
        load(1, 0, 0);
        measure();
    endtask

    task automatic t_psk();
        @(negedge clk); psk_sel = 1'b0;
        for (int i = 0; i < 8; i++) begin
            psk_code = 3'(i);
            load(0, 0, 1);
            chk($sformatf("R10 R9 code %0d", i), phase_out, exp_phase(32'h0, exp_psk(i)));
        end
    endtask

    task automatic t_po_hold();
        @(negedge clk); psk_code = 3'd3;
        tick(4);
        chk("R11 code change alone ignored", phase_out, exp_phase(32'h0, exp_psk(7)));
        @(negedge clk); psk_sel = 1'b1;
        tick(4);
        chk("R11 source change alone ignored", phase_out, exp_phase(32'h0, exp_psk(7)));
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_decode();
        t_unmapped();
        t_inhibit();
        t_wrap();
        t_init();
        t_hold_cf();
        t_phase_word();
        t_psk();
        t_po_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule